// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This unit adds or subtracts two 32-bit tagged words for a dynamically typed language runtime. Each word carries a small signed integer in bits 31..2 and a 2-bit type tag in bits 1..0. A tag of zero marks a plain small integer. Any other tag marks a word that the fast integer path must not handle, such as a pointer or a boxed value. The unit folds that condition into its overflow report. The runtime can then take its slow path on a single flag or trap.

Each accepted operation produces registered outputs one cycle later. In normal mode the result is always written and the overflow flag reports either a real signed overflow or a tag fault. In trap mode a faulting operation writes nothing, leaves the flags as they were, and raises a one-cycle trap request instead. Trap vectoring and the register file sit outside this block.

Top module: `tagged_addsub`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high, out_valid, trap_req, result and all four flags are 0.
- R2: An operation accepted with in_valid high produces its result on the next cycle. When op_sub is 0 the result is a+b modulo 2^32. When op_sub is 1 the result is a-b modulo 2^32. out_valid is high on that same cycle whenever the operation is written.
- R3: A tag fault exists when bits 1..0 of a or bits 1..0 of b are nonzero.
- R4: When trap_mode is 0, the result and flags are always written, and flag_v is 1 exactly when signed overflow or a tag fault occurs.
- R5: Signed overflow is judged on the full 32-bit two's-complement operation. It is set when the operands, after b is inverted for a subtract, have equal sign bits and the result's sign bit differs from them.
- R6: flag_z is 1 when the written 32-bit result is zero, and flag_n equals result bit 31. flag_c is the carry out of a+b for an add. For a subtract it is the carry out of a+~b+1, which is 1 when a >= b as unsigned numbers.
- R7: When trap_mode is 1 and signed overflow or a tag fault occurs, trap_req is 1 on the next cycle. On that cycle out_valid is 0, and result and the flags keep their previous values.
- R8: When trap_mode is 1 and neither condition occurs, the result and flags are written as in R2 and R6, flag_v is 0, and trap_req stays 0.
- R9: A cycle with in_valid low leaves result and flags unchanged. On the next cycle it drives out_valid and trap_req to 0.
- R10: out_valid and trap_req are never high on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| trap_mode | input | 1 | 1 selects the trapping variant |
| a | input | 32 | First tagged operand |
| b | input | 32 | Second tagged operand |
| out_valid | output | 1 | Result and flags were written this cycle |
| result | output | 32 | Registered sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result is negative |
| flag_c | output | 1 | Carry out |
| flag_v | output | 1 | Signed overflow or tag fault |
| trap_req | output | 1 | Trap request from the trapping variant |

## Verification
The assertions check several properties on every cycle:
- The trap and valid strobes are mutually exclusive.
- A trap cycle keeps the result and flags stable.
- Each strobe traces back to an accepted operation of the right mode.
- A tag fault in normal mode always shows up as flag_v.
- A written result in trap mode never carries flag_v.

Only the bench's scenarios can show that the arithmetic values are right. That covers the sums and differences, the carry and borrow convention, the sign-rule overflow at the integer limits, and the zero and negative flags. The bench compares these against its behavioural model on random operands, mixing zero and nonzero tags.

// File: rtl/tagged_addsub.sv
module tagged_addsub #(
  parameter int W     = 32,
  parameter int TAG_W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic         trap_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v,
  output logic         trap_req
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic [W-1:0] sum;
  logic         ovf, tag_fault, fault, take_trap, do_write;

  assign b_eff     = op_sub ? ~b : b;
  assign wide      = {1'b0, a} + {1'b0, b_eff} + (W+1)'(op_sub);
  assign sum       = wide[W-1:0];
  assign ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  assign tag_fault = (|a[TAG_W-1:0]) | (|b[TAG_W-1:0]);
  assign fault     = ovf | tag_fault;
  assign take_trap = in_valid & trap_mode & fault;
  assign do_write  = in_valid & ~take_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trap_req  <= 1'b0;
      result    <= '0;
      flag_z    <= 1'b0;
      flag_n    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= do_write;
      trap_req  <= take_trap;
      if (do_write) begin
        result <= sum;
        flag_z <= (sum == '0);
        flag_n <= sum[MSB];
        flag_c <= wide[W];
        flag_v <= fault;
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && trap_req));

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($stable(result) && $stable(flag_z) && $stable(flag_n)
                  && $stable(flag_c) && $stable(flag_v)));

  // R7
  trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(in_valid && trap_mode));

  // R9
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3
  tag_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trap_mode && ((|a[TAG_W-1:0]) || (|b[TAG_W-1:0])))
      |=> (out_valid && flag_v));

  // R8
  trap_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && trap_mode) |=> (!out_valid || !flag_v));
endmodule

// File: tb/tagged_addsub_tb.sv
`timescale 1ns/1ps
module tagged_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0, trap_mode = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, flag_z, flag_n, flag_c, flag_v, trap_req;
  logic [31:0] result;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_res;
  logic        m_val, m_trap, m_z, m_n, m_c, m_v;

  always #10 clk = ~clk;

  tagged_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .trap_mode(trap_mode), .a(a), .b(b), .out_valid(out_valid),
    .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .flag_v(flag_v), .trap_req(trap_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input bit v, input bit s, input bit tm,
                       input logic [31:0] x, input logic [31:0] y);
    longint ux, uy, uw;
    longint sx, sy, sw;
    logic [31:0] r;
    bit carry, ovf, tagf, flt;
    ux = longint'(x); uy = longint'(y);
    sx = longint'($signed(x)); sy = longint'($signed(y));
    if (s) begin
      uw = ux + (64'hFFFF_FFFF ^ uy) + 1;
      sw = sx - sy;
    end else begin
      uw = ux + uy;
      sw = sx + sy;
    end
    r     = uw[31:0];
    carry = uw[32];
    ovf   = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
    tagf  = (x[1:0] != 2'b00) || (y[1:0] != 2'b00);
    flt   = ovf || tagf;
    m_val  = 0;
    m_trap = 0;
    if (v) begin
      if (tm && flt) m_trap = 1;
      else begin
        m_val = 1;
        m_res = r; m_z = (r == 0); m_n = r[31]; m_c = carry; m_v = flt;
      end
    end
  endtask

  task automatic step(input string req, input bit v, input bit s, input bit tm,
                      input logic [31:0] x, input logic [31:0] y);
    in_valid = v; op_sub = s; trap_mode = tm; a = x; b = y;
    @(posedge clk);
    model(v, s, tm, x, y);
    @(negedge clk);
    chk(req, "out_valid", 32'(out_valid), 32'(m_val));
    chk(req, "trap_req",  32'(trap_req),  32'(m_trap));
    chk(req, "result",    result,         m_res);
    chk(req, "flag_z",    32'(flag_z),    32'(m_z));
    chk(req, "flag_n",    32'(flag_n),    32'(m_n));
    chk(req, "flag_c",    32'(flag_c),    32'(m_c));
    chk(req, "flag_v",    32'(flag_v),    32'(m_v));
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_res = 0; m_val = 0; m_trap = 0; m_z = 0; m_n = 0; m_c = 0; m_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "result", result, 0);
    chk("R1", "flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);
    // R2 plain add and subtract
    step("R2", 1, 0, 0, 32'h0000_0014, 32'h0000_0008);
    step("R2", 1, 1, 0, 32'h0000_0014, 32'h0000_0008);
    // R6 zero result and borrow
    step("R6", 1, 1, 0, 32'h0000_0010, 32'h0000_0010);
    step("R6", 1, 1, 0, 32'h0000_0004, 32'h0000_0010);
    step("R6", 1, 0, 0, 32'hFFFF_FFFC, 32'h0000_0008);
    // R5 overflow at limits
    step("R5", 1, 0, 0, 32'h7FFF_FFFC, 32'h0000_0004);
    step("R5", 1, 1, 0, 32'h8000_0000, 32'h0000_0004);
    // R3 / R4 tag faults, normal mode
    step("R3", 1, 0, 0, 32'h0000_0011, 32'h0000_0004);
    step("R4", 1, 1, 0, 32'h0000_0010, 32'h0000_0002);
    // R7 trap on tag fault and on overflow, result held
    step("R7", 1, 0, 1, 32'h0000_0023, 32'h0000_0004);
    step("R7", 1, 0, 1, 32'h7FFF_FFFC, 32'h7FFF_FFFC);
    // R8 trap mode clean op
    step("R8", 1, 0, 1, 32'h0000_0100, 32'h0000_0040);
    // R9 idle hold
    step("R9", 0, 1, 1, 32'hDEAD_BEEF, 32'h0000_0003);
    step("R9", 0, 0, 0, 32'h1234_5678, 32'h0000_0001);
    // R10 random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if ($urandom_range(0, 2) != 0) x[1:0] = 2'b00;
      if ($urandom_range(0, 2) != 0) y[1:0] = 2'b00;
      step("R10", $urandom_range(0, 4) != 0, 1'($urandom),
           1'($urandom), x, y);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule